// File: doc/BRIEF.md
# Parallel NOR Flash Erase Sequencer

This block turns a single erase request into the full bus activity an 8-bit asynchronous parallel NOR flash expects. A request names the erase kind and, for a sector erase, the sector. The kind is either the whole device or one 64 KiB sector out of 128. While idle the block takes the request and then drives six command writes. The first five are the same for both kinds. The sixth selects between the device-wide erase and the single-sector erase.

After the command, the block waits a fixed poll interval and reads the target location. It keeps doing this until the location returns all ones or the attempt budget for that erase kind is used up. For a sector erase the target is the sector's base address; for a whole-device erase it is address zero. The block then raises `done` for one clock, with `pass` showing whether the erased value was seen.

The poll interval comes from a clock prescaler parameter. At the default 250 MHz clock it gives 100 ms, and a short value can be set for simulation. The host side is a plain valid strobe. A request made while an erase is running is dropped.

Top module: `nor_erase_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `fl_dout_en` are 0 and `fl_ce_n`, `fl_we_n`, `fl_oe_n` are all 1.
- R2: An accepted request first produces exactly five bus writes in this order (offset/data): 0xAAA/0xAA, 0x555/0x55, 0xAAA/0x80, 0xAAA/0xAA, 0x555/0x55. Offsets are placed in the low bits of `fl_addr` with all upper bits zero.
- R3: The sixth write is data 0x10 to offset 0xAAA when `req_whole`=1. When `req_whole`=0 it is data 0x30 to the sector base address `{req_sector, 16'h0000}`.
- R4: For every write, `fl_addr` and `fl_dout` hold their values and `fl_dout_en` is 1 for one clock before `fl_we_n` falls. `fl_ce_n` and `fl_we_n` are then low for exactly STROBE_CLKS clocks. The values hold one further clock after `fl_we_n` rises.
- R5: Every poll read addresses the target location: `{req_sector, 16'h0000}` for a sector erase, or 0 for a whole-device erase. Before each poll read, including the first, the bus stays inactive (`fl_ce_n`=1) for at least TICK_CLKS clocks.
- R6: When a poll read returns 0xFF, no further reads are issued, and `done` pulses with `pass`=1.
- R7: If none of the first SECTOR_POLLS reads (sector erase) or CHIP_POLLS reads (whole-device erase) returns 0xFF, exactly that many reads are made, and `done` pulses with `pass`=0.
- R8: `done` is high for a single clock per request. `busy` rises the clock after acceptance, stays high through the `done` clock, and is low on the clock after.
- R9: A request presented while `busy` is 1 has no effect: the command writes, the poll reads and the result of the erase in progress are unchanged.
- R10: During a poll read, `fl_ce_n` and `fl_oe_n` are low for exactly STROBE_CLKS clocks, `fl_we_n` stays 1, and `fl_dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request strobe, taken only while idle |
| req_whole | input | 1 | 1 = erase whole device, 0 = erase one sector |
| req_sector | input | SECTOR_W | Sector index for a sector erase |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-clock completion pulse |
| pass | output | 1 | Result, valid with `done`: 1 = erased value seen |
| fl_addr | output | SECTOR_W+SPAN_W | Flash byte address |
| fl_dout | output | 8 | Flash write data |
| fl_dout_en | output | 1 | Data bus drive enable |
| fl_din | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds the block with STROBE_CLKS=2, TICK_CLKS=20, SECTOR_POLLS=40 and CHIP_POLLS=60. The short interval and the reduced whole-device budget let budget exhaustion of both erase kinds finish within a few thousand clocks. The default sector budget is kept, so the first-to-last-attempt boundary is tested at its real value. A two-clock strobe exercises the multi-clock strobe counter. The sector range covers index 0 and the top index 127.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    localparam int          BYTE_W    = 8;
    localparam int          OFS_W     = 12;
    localparam int          CMD_STEPS = 6;
    localparam logic [7:0]  ERASED    = 8'hFF;
    localparam logic [11:0] OFS_HI    = 12'hAAA;
    localparam logic [11:0] OFS_LO    = 12'h555;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_CMD_WAIT,
        SQ_POLL_WAIT,
        SQ_POLL_RD,
        SQ_POLL_RD_WAIT,
        SQ_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        CY_IDLE,
        CY_SETUP,
        CY_STROBE,
        CY_HOLD
    } cyc_phase_t;

    typedef struct packed {
        logic [OFS_W-1:0]  offset;
        logic [BYTE_W-1:0] data;
        logic              to_sector;
    } cmd_word_t;

    function automatic cmd_word_t cmd_word(input logic [2:0] step, input logic whole);
        cmd_word_t w;
        case (step)
            3'd0:    w = '{offset: OFS_HI, data: 8'hAA, to_sector: 1'b0};
            3'd1:    w = '{offset: OFS_LO, data: 8'h55, to_sector: 1'b0};
            3'd2:    w = '{offset: OFS_HI, data: 8'h80, to_sector: 1'b0};
            3'd3:    w = '{offset: OFS_HI, data: 8'hAA, to_sector: 1'b0};
            3'd4:    w = '{offset: OFS_LO, data: 8'h55, to_sector: 1'b0};
            default: w = whole ? '{offset: OFS_HI, data: 8'h10, to_sector: 1'b0}
                               : '{offset: '0,     data: 8'h30, to_sector: 1'b1};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/nor_poll_tick.sv
module nor_poll_tick #(
    parameter int TICK_CLKS = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int TICK_W = $clog2(TICK_CLKS + 1);

    logic [TICK_W-1:0] cnt_q;

    assign tick = run && (cnt_q == TICK_W'(TICK_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
    import nor_erase_pkg::*;
#(
    parameter int ADDR_W      = 23,
    parameter int STROBE_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              finish,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [BYTE_W-1:0] bus_din,
    output logic              bus_ce_n,
    output logic              bus_we_n,
    output logic              bus_oe_n
);
    localparam int CNT_W = $clog2(STROBE_CLKS + 1);

    cyc_phase_t        phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] rd_q;
    logic              last_strobe;

    assign last_strobe = (phase_q == CY_STROBE) && (cnt_q == CNT_W'(STROBE_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= CY_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            rd_q    <= '0;
        end else begin
            case (phase_q)
                CY_IDLE: if (start) begin
                    phase_q <= CY_SETUP;
                    wr_q    <= wr;
                    addr_q  <= addr;
                    data_q  <= wdata;
                end
                CY_SETUP: begin
                    phase_q <= CY_STROBE;
                    cnt_q   <= '0;
                end
                CY_STROBE: begin
                    if (last_strobe) begin
                        phase_q <= CY_HOLD;
                        if (!wr_q) rd_q <= bus_din;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= CY_IDLE;
            endcase
        end
    end

    assign finish      = (phase_q == CY_HOLD);
    assign rdata       = rd_q;
    assign bus_addr    = addr_q;
    assign bus_dout    = data_q;
    assign bus_dout_en = wr_q && (phase_q != CY_IDLE);
    assign bus_ce_n    = (phase_q != CY_STROBE);
    assign bus_we_n    = !((phase_q == CY_STROBE) && wr_q);
    assign bus_oe_n    = !((phase_q == CY_STROBE) && !wr_q);

    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (rst)
        (phase_q == CY_STROBE && !last_strobe) |=> (phase_q == CY_STROBE)); // R4

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int SECTOR_W     = 7,
    parameter int SPAN_W       = 16,
    parameter int STROBE_CLKS  = 2,
    parameter int TICK_CLKS    = 25_000_000,
    parameter int SECTOR_POLLS = 40,
    parameter int CHIP_POLLS   = 20000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_whole,
    input  logic [SECTOR_W-1:0]        req_sector,
    output logic                       busy,
    output logic                       done,
    output logic                       pass,
    output logic [SECTOR_W+SPAN_W-1:0] fl_addr,
    output logic [7:0]                 fl_dout,
    output logic                       fl_dout_en,
    input  logic [7:0]                 fl_din,
    output logic                       fl_ce_n,
    output logic                       fl_we_n,
    output logic                       fl_oe_n
);
    localparam int ADDR_W    = SECTOR_W + SPAN_W;
    localparam int MAX_POLLS = (CHIP_POLLS > SECTOR_POLLS) ? CHIP_POLLS : SECTOR_POLLS;
    localparam int TRY_W     = $clog2(MAX_POLLS + 1);

    seq_state_t          state_q;
    logic                whole_q;
    logic [SECTOR_W-1:0] sector_q;
    logic [2:0]          step_q;
    logic [TRY_W-1:0]    tries_q;
    logic                pass_q;

    cmd_word_t           cmd;
    logic [ADDR_W-1:0]   target;
    logic [ADDR_W-1:0]   cyc_addr;
    logic                cyc_start;
    logic                cyc_wr;
    logic                cyc_finish;
    logic [BYTE_W-1:0]   cyc_rdata;
    logic                tick;

    assign cmd       = cmd_word(step_q, whole_q);
    assign target    = {sector_q & {SECTOR_W{~whole_q}}, {SPAN_W{1'b0}}};
    assign cyc_start = (state_q == SQ_CMD) || (state_q == SQ_POLL_RD);
    assign cyc_wr    = (state_q == SQ_CMD);
    assign cyc_addr  = (state_q == SQ_POLL_RD || cmd.to_sector) ? target
                     : {{(ADDR_W-OFS_W){1'b0}}, cmd.offset};

    nor_poll_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk (clk),
        .rst (rst),
        .run (state_q == SQ_POLL_WAIT),
        .tick(tick)
    );

    nor_bus_cycle #(.ADDR_W(ADDR_W), .STROBE_CLKS(STROBE_CLKS)) u_cycle (
        .clk        (clk),
        .rst        (rst),
        .start      (cyc_start),
        .wr         (cyc_wr),
        .addr       (cyc_addr),
        .wdata      (cmd.data),
        .rdata      (cyc_rdata),
        .finish     (cyc_finish),
        .bus_addr   (fl_addr),
        .bus_dout   (fl_dout),
        .bus_dout_en(fl_dout_en),
        .bus_din    (fl_din),
        .bus_ce_n   (fl_ce_n),
        .bus_we_n   (fl_we_n),
        .bus_oe_n   (fl_oe_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            whole_q  <= 1'b0;
            sector_q <= '0;
            step_q   <= '0;
            tries_q  <= '0;
            pass_q   <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: if (req_valid) begin
                    whole_q  <= req_whole;
                    sector_q <= req_sector;
                    step_q   <= '0;
                    tries_q  <= req_whole ? TRY_W'(CHIP_POLLS) : TRY_W'(SECTOR_POLLS);
                    pass_q   <= 1'b0;
                    state_q  <= SQ_CMD;
                end
                SQ_CMD: state_q <= SQ_CMD_WAIT;
                SQ_CMD_WAIT: if (cyc_finish) begin
                    if (step_q == 3'(CMD_STEPS - 1)) begin
                        state_q <= SQ_POLL_WAIT;
                    end else begin
                        step_q  <= step_q + 1'b1;
                        state_q <= SQ_CMD;
                    end
                end
                SQ_POLL_WAIT: if (tick) state_q <= SQ_POLL_RD;
                SQ_POLL_RD:   state_q <= SQ_POLL_RD_WAIT;
                SQ_POLL_RD_WAIT: if (cyc_finish) begin
                    if (cyc_rdata == ERASED) begin
                        pass_q  <= 1'b1;
                        state_q <= SQ_FINISH;
                    end else if (tries_q == TRY_W'(1)) begin
                        pass_q  <= 1'b0;
                        state_q <= SQ_FINISH;
                    end else begin
                        tries_q <= tries_q - 1'b1;
                        state_q <= SQ_POLL_WAIT;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (state_q != SQ_IDLE);
    assign done = (state_q == SQ_FINISH);
    assign pass = pass_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R8
    AST_REQ_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> ($stable(whole_q) && $stable(sector_q))); // R9
    AST_WR_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dout))); // R4
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> ($stable(fl_addr) && fl_dout_en)); // R4
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (!fl_dout_en && fl_we_n)); // R10
    AST_READ_TARGET: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (fl_addr == target)); // R5

endmodule

// File: tb/test_nor_erase_seq.sv
`timescale 1ns/1ps
module test_nor_erase_seq;
    localparam int P_SECW   = 7;
    localparam int P_SPAN   = 16;
    localparam int P_AW     = P_SECW + P_SPAN;
    localparam int P_STROBE = 2;
    localparam int P_TICK   = 20;
    localparam int P_SPOLLS = 40;
    localparam int P_CPOLLS = 60;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_whole = 1'b0;
    logic [P_SECW-1:0] req_sector = '0;
    logic              busy, done, pass;
    logic [P_AW-1:0]   fl_addr;
    logic [7:0]        fl_dout, fl_din;
    logic              fl_dout_en, fl_ce_n, fl_we_n, fl_oe_n;

    always #2 clk = ~clk;

    nor_erase_seq #(
        .SECTOR_W(P_SECW), .SPAN_W(P_SPAN), .STROBE_CLKS(P_STROBE),
        .TICK_CLKS(P_TICK), .SECTOR_POLLS(P_SPOLLS), .CHIP_POLLS(P_CPOLLS)
    ) i_nor_erase_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_whole(req_whole),
        .req_sector(req_sector), .busy(busy), .done(done), .pass(pass),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en),
        .fl_din(fl_din), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural flash / bus monitor state
    int              ff_at = 0;
    int              n_wr, n_rd, wr_tim_err, rd_tim_err, rd_addr_err, min_gap, done_cnt;
    logic [P_AW-1:0] exp_tgt;
    logic [P_AW-1:0] wr_addr_log [0:15];
    logic [7:0]      wr_data_log [0:15];
    logic            got_pass;
    logic            prev_we = 1'b1, prev_oe = 1'b1, prev_den = 1'b0;
    logic [P_AW-1:0] prev_addr = '0;
    logic [7:0]      prev_dout = '0;
    int              slen = 0, idle_run = 0;

    assign fl_din = !fl_oe_n ? ((ff_at != 0 && n_rd >= ff_at) ? 8'hFF : {1'b0, 7'(n_rd)}) : 8'h00;

    always @(negedge clk) begin
        if (!rst) begin
            if (!fl_we_n && prev_we) begin
                if (n_wr < 16) begin
                    wr_addr_log[n_wr] = fl_addr;
                    wr_data_log[n_wr] = fl_dout;
                end
                n_wr++;
                if (prev_addr !== fl_addr || prev_dout !== fl_dout || !prev_den || fl_ce_n) wr_tim_err++;
                slen = 1;
            end else if (!fl_we_n) begin
                if (prev_addr !== fl_addr || prev_dout !== fl_dout || fl_ce_n) wr_tim_err++;
                slen++;
            end else if (!prev_we) begin
                if (slen != P_STROBE || prev_addr !== fl_addr || !fl_dout_en) wr_tim_err++;
            end
            if (!fl_oe_n && prev_oe) begin
                n_rd++;
                if (fl_addr !== exp_tgt) rd_addr_err++;
                if (idle_run < min_gap) min_gap = idle_run;
                if (fl_dout_en || !fl_we_n || fl_ce_n) rd_tim_err++;
                slen = 1;
            end else if (!fl_oe_n) begin
                if (fl_dout_en || !fl_we_n || fl_ce_n) rd_tim_err++;
                slen++;
            end else if (!prev_oe) begin
                if (slen != P_STROBE) rd_tim_err++;
            end
            if (done) begin
                done_cnt++;
                got_pass = pass;
            end
            idle_run = fl_ce_n ? idle_run + 1 : 0;
        end
        prev_we   = fl_we_n;
        prev_oe   = fl_oe_n;
        prev_den  = fl_dout_en;
        prev_addr = fl_addr;
        prev_dout = fl_dout;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [P_AW-1:0] exp_wr_addr(input int step, input bit whole, input int sec);
        case (step)
            0, 2, 3: return P_AW'(12'hAAA);
            1, 4:    return P_AW'(12'h555);
            default: return whole ? P_AW'(12'hAAA) : P_AW'(sec) << P_SPAN;
        endcase
    endfunction

    function automatic logic [7:0] exp_wr_data(input int step, input bit whole);
        case (step)
            0, 3:    return 8'hAA;
            1, 4:    return 8'h55;
            2:       return 8'h80;
            default: return whole ? 8'h10 : 8'h30;
        endcase
    endfunction

    task automatic run_erase(input bit whole, input int sec, input int ffat, input int inj_at);
        int budget, exp_rd, cyc;
        bit exp_pass;
        n_wr = 0; n_rd = 0; wr_tim_err = 0; rd_tim_err = 0; rd_addr_err = 0;
        min_gap = 1_000_000; done_cnt = 0; got_pass = 1'b0;
        ff_at   = ffat;
        exp_tgt = whole ? '0 : (P_AW'(sec) << P_SPAN);
        budget  = whole ? P_CPOLLS : P_SPOLLS;
        exp_rd  = (ffat != 0 && ffat <= budget) ? ffat : budget;
        exp_pass = (ffat != 0 && ffat <= budget);
        @(negedge clk);
        req_valid = 1'b1; req_whole = whole; req_sector = P_SECW'(sec);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R8 busy after accept", busy, 1);
        cyc = 0;
        while (done !== 1'b1 && cyc < 50000) begin
            @(negedge clk);
            cyc++;
            if (cyc == inj_at && busy) begin
                req_valid = 1'b1; req_whole = ~whole; req_sector = ~P_SECW'(sec);
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R8 done single pulse, busy released", {done, busy}, 0);
        check(done_cnt == 1, "R8 done count", done_cnt, 1);
        check(n_wr == 6, "R2 write count", n_wr, 6);
        for (int i = 0; i < 6 && i < n_wr; i++) begin
            check(wr_addr_log[i] === exp_wr_addr(i, whole, sec) && wr_data_log[i] === exp_wr_data(i, whole),
                  (i < 5) ? "R2 command write" : "R3 final command write",
                  {wr_addr_log[i], wr_data_log[i]}, {exp_wr_addr(i, whole, sec), exp_wr_data(i, whole)});
        end
        check(wr_tim_err == 0, "R4 write strobe timing", wr_tim_err, 0);
        check(rd_tim_err == 0, "R10 read strobe timing", rd_tim_err, 0);
        check(rd_addr_err == 0, "R5 poll address", rd_addr_err, 0);
        check(min_gap >= P_TICK, "R5 poll interval", min_gap, P_TICK);
        check(n_rd == exp_rd, exp_pass ? "R6 read count" : "R7 read count", n_rd, exp_rd);
        check(got_pass === exp_pass, exp_pass ? "R6 pass status" : "R7 fail status", got_pass, exp_pass);
        if (inj_at > 0)
            check(n_wr == 6 && n_rd == exp_rd && got_pass === exp_pass, "R9 busy request ignored",
                  n_rd, exp_rd);
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                while (wd < 190_000) begin
                    @(posedge clk);
                    wd++;
                end
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual=%0d expected=<190000 cycles", wd);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        join_none
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0 && fl_dout_en === 1'b0, "R1 reset status",
              {busy, done, fl_dout_en}, 0);
        check(fl_ce_n === 1'b1 && fl_we_n === 1'b1 && fl_oe_n === 1'b1, "R1 reset strobes",
              {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);

        run_erase(1'b0, 0,   1,  0);           // R6 first read erased
        run_erase(1'b0, 127, 40, 0);           // R6 erased on last allowed attempt
        run_erase(1'b0, 5,   41, 0);           // R7 one past the budget
        run_erase(1'b0, 64,  0,  0);           // R7 never erased
        run_erase(1'b1, 9,   3,  0);           // R3 whole-device, pass
        run_erase(1'b1, 0,   0,  0);           // R7 whole-device budget
        run_erase(1'b0, 33,  4,  3);           // R9 during command writes
        run_erase(1'b1, 0,   5,  60);          // R9 during polling

        for (int k = 0; k < 10; k++) begin
            bit w;
            int s, f, inj;
            w   = ($urandom_range(0, 3) == 0);
            s   = $urandom_range(0, 127);
            f   = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, w ? 65 : 45);
            inj = ($urandom_range(0, 1) == 1) ? $urandom_range(1, 80) : 0;
            run_erase(w, s, f, inj);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule